// File: doc/BRIEF.md
# Block-Transfer Micro-op Sequencer

This block accepts one 32-bit multi-register transfer instruction and breaks it into a stream of single-register micro-ops, one per clock, under a valid/ready handshake on each side. Instruction bits 24:20 hold, from most to least significant, the pre/post flag P, the up/down flag U, a reserved flag S, the writeback flag W and the load flag L. Bits 19:16 name the base register and bits 15:0 are the register list.

The stream opens with a base-copy micro-op. One transfer micro-op then follows for each register in the list, carrying an offset magnitude and a direction relative to the base. An optional base-writeback micro-op closes the stream, and the final micro-op of every stream carries an end flag. The sequencer is a four-state machine. IDLE accepts an instruction: a legal one moves to BASE, an illegal one stays in IDLE. BASE goes to XFER when the list is non-empty, otherwise to WBACK when W=1, otherwise back to IDLE. XFER repeats until the list is used up and then goes to WBACK when W=1, otherwise to IDLE. WBACK returns to IDLE. A state moves on only when its micro-op is accepted.

Top module: `lsm_uop_seq`

## Requirements
- R1: A mode pattern with S (bit 22) set is illegal. The instruction is consumed, `illegal` is high for exactly the one cycle after acceptance, no micro-op is emitted, and `in_ready` stays high.
- R2: The first micro-op has kind 0 (base copy). Its encoding is instruction bits 31:16 followed by sixteen zero bits, its register field is the base register (bits 19:16), its offset is 0 and its up flag is 1.
- R3: With n set bits in the list, the first transfer offset is 4n-4 when P=0,U=0; 0 when P=0,U=1; 4n when P=1,U=0; and 4 when P=1,U=1.
- R4: Each later transfer offset is the previous one plus 4 when U=1 and minus 4 when U=0. Every transfer carries up flag = U.
- R5: Transfers have kind 1 and encoding 0. They visit the listed registers in ascending number order, the register field holds that number, and the load flag equals L.
- R6: When W=1 a final micro-op of kind 2 is emitted. Its encoding is bits 31:28 of the instruction, OR 0x02400000, OR the base register in both bits 19:16 and 15:12, OR 4n in the low bits. Its offset is 4n, its up flag is U and its register field is the base register.
- R7: A stream holds exactly 1+n+W micro-ops, and only the final one has `out_last` set. After the last handshake the block is idle on the next cycle.
- R8: `in_ready` is high only in IDLE. An instruction offered while a stream is pending is ignored and does not change that stream.
- R9: While `out_valid` is high and `out_ready` is low, every output field holds its value.
- R10: A synchronous reset discards any partial stream and leaves the block idle, with `in_ready` high and `out_valid` and `illegal` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, instruction may be taken |
| in_instr | input | 32 | Block-transfer instruction |
| illegal | output | 1 | One-cycle flag for a rejected mode pattern |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Consumer takes the micro-op |
| out_kind | output | 2 | 0 base copy, 1 transfer, 2 writeback |
| out_load | output | 1 | Transfer is a load |
| out_reg | output | 4 | Register number |
| out_offset | output | 7 | Offset magnitude |
| out_up | output | 1 | 1 add offset to base, 0 subtract |
| out_encoding | output | 32 | Encoded instruction word for base copy and writeback |
| out_last | output | 1 | Final micro-op of the stream |

## Verification
The bench targets four groups of cases. The first is the four offset modes: a design that mixed up the before and after starting points would be off by exactly 4 on every transfer. The second is the empty list with and without writeback, where a design that misplaced the end flag would emit an extra micro-op or hang. The third is the full sixteen-register list, which takes the offset to its widest value and would expose a truncated offset or count. The fourth covers illegal patterns, instructions offered mid-stream, back-pressure and a reset in mid-stream: a design that mishandled these would emit stray micro-ops, corrupt the pending stream, or resume an abandoned one.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    localparam int REGS  = 16;
    localparam int CNT_W = $clog2(REGS + 1);
    localparam int OFF_W = $clog2(4 * REGS + 1);
    localparam int RN_W  = $clog2(REGS);

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_BASE  = 2'd1,
        S_XFER  = 2'd2,
        S_WBACK = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        K_BASE = 2'd0,
        K_XFER = 2'd1,
        K_WB   = 2'd2
    } uop_kind_t;

    localparam logic [31:0] WB_OPCODE = 32'h0240_0000;
endpackage

// File: rtl/lsm_mode_decode.sv
module lsm_mode_decode
    import lsm_pkg::*;
(
    input  logic [31:0]      instr,
    output logic             legal,
    output logic             pre,
    output logic             up,
    output logic             wback,
    output logic             load,
    output logic [RN_W-1:0]  base_rn,
    output logic [REGS-1:0]  list,
    output logic [CNT_W-1:0] n_regs,
    output logic [OFF_W-1:0] start_off
);
    logic [OFF_W-1:0] four_n;

    always_comb begin
        pre     = instr[24];
        up      = instr[23];
        legal   = !instr[22];
        wback   = instr[21];
        load    = instr[20];
        base_rn = instr[16 +: RN_W];
        list    = instr[REGS-1:0];
        n_regs  = '0;
        for (int i = 0; i < REGS; i++) begin
            n_regs = n_regs + CNT_W'(list[i]);
        end
        four_n = OFF_W'({n_regs, 2'b00});
        unique case ({pre, up})
            2'b00:   start_off = (n_regs != '0) ? four_n - OFF_W'(4) : '0;
            2'b01:   start_off = '0;
            2'b10:   start_off = four_n;
            default: start_off = OFF_W'(4);
        endcase
    end
endmodule

// File: rtl/lsm_pick_lowest.sv
module lsm_pick_lowest
    import lsm_pkg::*;
(
    input  logic [REGS-1:0] list,
    output logic [RN_W-1:0] idx,
    output logic [REGS-1:0] rest,
    output logic            rest_empty
);
    always_comb begin
        idx = '0;
        for (int i = REGS - 1; i >= 0; i--) begin
            if (list[i]) idx = RN_W'(i);
        end
        rest       = list & ~(REGS'(1) << idx);
        rest_empty = (rest == '0);
    end
endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
    import lsm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_instr,
    output logic        illegal,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [1:0]  out_kind,
    output logic        out_load,
    output logic [3:0]  out_reg,
    output logic [6:0]  out_offset,
    output logic        out_up,
    output logic [31:0] out_encoding,
    output logic        out_last
);
    seq_state_t       state;
    logic [31:0]      ins_q;
    logic [REGS-1:0]  list_q;
    logic [OFF_W-1:0] off_q;
    logic [CNT_W-1:0] n_q;
    logic             up_q, load_q, wb_q, illegal_q;
    logic [RN_W-1:0]  rn_q;

    logic             d_legal, d_pre, d_up, d_wb, d_load;
    logic [RN_W-1:0]  d_rn;
    logic [REGS-1:0]  d_list;
    logic [CNT_W-1:0] d_n;
    logic [OFF_W-1:0] d_off;
    logic [RN_W-1:0]  pick_idx;
    logic [REGS-1:0]  pick_rest;
    logic             pick_rest_empty;
    logic             accept, fire;

    lsm_mode_decode u_dec (
        .instr     (in_instr),
        .legal     (d_legal),
        .pre       (d_pre),
        .up        (d_up),
        .wback     (d_wb),
        .load      (d_load),
        .base_rn   (d_rn),
        .list      (d_list),
        .n_regs    (d_n),
        .start_off (d_off)
    );

    lsm_pick_lowest u_pick (
        .list       (list_q),
        .idx        (pick_idx),
        .rest       (pick_rest),
        .rest_empty (pick_rest_empty)
    );

    assign accept = in_valid && (state == S_IDLE);
    assign fire   = out_valid && out_ready;

    // state register and sequence context
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            ins_q     <= '0;
            list_q    <= '0;
            off_q     <= '0;
            n_q       <= '0;
            up_q      <= 1'b0;
            load_q    <= 1'b0;
            wb_q      <= 1'b0;
            rn_q      <= '0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= accept && !d_legal;
            unique case (state)
                S_IDLE: begin
                    if (accept && d_legal) begin
                        state  <= S_BASE;
                        ins_q  <= in_instr;
                        list_q <= d_list;
                        off_q  <= d_off;
                        n_q    <= d_n;
                        up_q   <= d_up;
                        load_q <= d_load;
                        wb_q   <= d_wb;
                        rn_q   <= d_rn;
                    end
                end
                S_BASE: begin
                    if (fire) begin
                        if (list_q != '0) state <= S_XFER;
                        else if (wb_q)    state <= S_WBACK;
                        else              state <= S_IDLE;
                    end
                end
                S_XFER: begin
                    if (fire) begin
                        list_q <= pick_rest;
                        off_q  <= up_q ? off_q + OFF_W'(4) : off_q - OFF_W'(4);
                        if (pick_rest_empty) state <= wb_q ? S_WBACK : S_IDLE;
                    end
                end
                S_WBACK: begin
                    if (fire) state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready     = (state == S_IDLE);
        illegal      = illegal_q;
        out_valid    = 1'b0;
        out_kind     = K_BASE;
        out_load     = 1'b0;
        out_reg      = rn_q;
        out_offset   = '0;
        out_up       = 1'b1;
        out_encoding = '0;
        out_last     = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_BASE: begin
                out_valid    = 1'b1;
                out_encoding = {ins_q[31:16], 16'h0000};
                out_last     = (list_q == '0) && !wb_q;
            end
            S_XFER: begin
                out_valid  = 1'b1;
                out_kind   = K_XFER;
                out_load   = load_q;
                out_reg    = pick_idx;
                out_offset = off_q;
                out_up     = up_q;
                out_last   = pick_rest_empty && !wb_q;
            end
            S_WBACK: begin
                out_valid    = 1'b1;
                out_kind     = K_WB;
                out_offset   = OFF_W'({n_q, 2'b00});
                out_up       = up_q;
                out_encoding = {ins_q[31:28], 28'h0} | WB_OPCODE
                             | (32'(rn_q) << 16) | (32'(rn_q) << 12)
                             | 32'({n_q, 2'b00});
                out_last     = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lsm_seq_checker.sv
module lsm_seq_checker
    import lsm_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        illegal,
    input logic        out_valid,
    input logic        out_ready,
    input logic [1:0]  out_kind,
    input logic [6:0]  out_offset,
    input logic        out_up,
    input logic [3:0]  out_reg,
    input logic [31:0] out_encoding,
    input logic        out_last
);
    assert_illegal_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!out_valid && in_ready));

    assert_base_fields_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == K_BASE) |-> (out_offset == '0 && out_up && out_encoding[15:0] == 16'h0));

    assert_offset_step_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_kind == K_XFER) |=>
        (!(out_valid && out_kind == K_XFER) ||
         (out_up ? out_offset == $past(out_offset) + 7'd4
                 : out_offset == $past(out_offset) - 7'd4)));

    assert_last_valid_R7: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    assert_idle_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> in_ready);

    assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_kind) && $stable(out_offset) && $stable(out_reg)
         && $stable(out_encoding) && $stable(out_last) && $stable(out_up)));

    assert_reset_idle_R10: assert property (@(posedge clk)
        rst |=> (in_ready && !out_valid && !illegal));
endmodule

bind lsm_uop_seq lsm_seq_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .illegal      (illegal),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_kind     (out_kind),
    .out_offset   (out_offset),
    .out_up       (out_up),
    .out_reg      (out_reg),
    .out_encoding (out_encoding),
    .out_last     (out_last)
);

// File: tb/sim_lsm_uop_seq.sv
module sim_lsm_uop_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_instr = '0;
    logic        illegal;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [1:0]  out_kind;
    logic        out_load;
    logic [3:0]  out_reg;
    logic [6:0]  out_offset;
    logic        out_up;
    logic [31:0] out_encoding;
    logic        out_last;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lsm_uop_seq u0 (.*);

    localparam int NV = 10;
    localparam logic [31:0] VEC_INSTR [0:NV-1] = '{
        32'hE8BD_8010, 32'hE92D_4FF0, 32'hE810_0003, 32'hE990_0000, 32'hE8A0_0000,
        32'hE9B1_FFFF, 32'h0830_8001, 32'hE93C_0400, 32'hE8FD_0001, 32'hE9D0_0000
    };
    localparam int VEC_CNT [0:NV-1] = '{4, 11, 3, 1, 2, 18, 4, 3, 0, 0};

    logic [1:0]  e_kind [0:17];
    logic        e_load [0:17];
    logic [3:0]  e_reg  [0:17];
    logic [6:0]  e_off  [0:17];
    logic        e_up   [0:17];
    logic [31:0] e_enc  [0:17];
    logic        e_last [0:17];
    int          e_cnt;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference model built from the requirements
    task automatic build_expect(input logic [31:0] ins);
        int n, off, k;
        logic [3:0] rn;
        n = $countones(ins[15:0]);
        rn = ins[19:16];
        e_cnt = 0;
        if (ins[22]) return;
        case ({ins[24], ins[23]})
            2'b00: off = (n > 0) ? 4 * n - 4 : 0;
            2'b01: off = 0;
            2'b10: off = 4 * n;
            default: off = 4;
        endcase
        e_kind[0] = 2'd0; e_load[0] = 1'b0; e_reg[0] = rn; e_off[0] = '0; e_up[0] = 1'b1;
        e_enc[0] = {ins[31:16], 16'h0};
        k = 1;
        for (int r = 0; r < 16; r++) begin
            if (ins[r]) begin
                e_kind[k] = 2'd1; e_load[k] = ins[20]; e_reg[k] = 4'(r);
                e_off[k] = 7'(off); e_up[k] = ins[23]; e_enc[k] = '0;
                off = ins[23] ? off + 4 : off - 4;
                k++;
            end
        end
        if (ins[21]) begin
            e_kind[k] = 2'd2; e_load[k] = 1'b0; e_reg[k] = rn; e_off[k] = 7'(4 * n);
            e_up[k] = ins[23];
            e_enc[k] = {ins[31:28], 28'h0} | 32'h0240_0000 | (32'(rn) << 16)
                     | (32'(rn) << 12) | 32'(4 * n);
            k++;
        end
        e_cnt = k;
        for (int i = 0; i < 18; i++) e_last[i] = (i == k - 1);
    endtask

    task automatic offer(input logic [31:0] ins);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_instr = ins;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // collect a stream with a stall pattern; returns number of micro-ops taken
    task automatic collect(input logic [31:0] ins, output int got);
        bit done, busy_ok;
        string tag;
        int guard;
        got = 0; done = 0; busy_ok = 1; guard = 0;
        while (!done && guard < 200) begin
            out_ready = (cyc % 3 != 1);
            #1;
            if (out_valid && in_ready) busy_ok = 0;
            if (out_valid && out_ready) begin
                if (got < 18) begin
                    tag = (e_kind[got] == 2'd0) ? "R2" : (e_kind[got] == 2'd1) ? "R3/R4/R5" : "R6";
                    check(out_kind == e_kind[got] && out_load == e_load[got] &&
                          out_reg == e_reg[got] && out_offset == e_off[got] &&
                          out_up == e_up[got] && out_encoding == e_enc[got],
                          tag, $sformatf("uop %0d of %08h", got, ins),
                          {out_kind, out_load, out_reg, out_offset, out_up, out_encoding},
                          {e_kind[got], e_load[got], e_reg[got], e_off[got], e_up[got], e_enc[got]});
                    check(out_last == e_last[got], "R7", "last flag", 64'(out_last), 64'(e_last[got]));
                end
                got++;
                if (out_last) done = 1;
            end
            @(negedge clk);
            guard++;
        end
        out_ready = 1'b0;
        check(busy_ok, "R8", "in_ready low while busy", 64'(busy_ok), 64'd1);
    endtask

    task automatic finish_up;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        int got;
        logic [31:0] hold_enc;
        logic [6:0]  hold_off;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(in_ready && !out_valid && !illegal, "R10", "reset state",
              {61'd0, in_ready, out_valid, illegal}, 64'b100);

        // table walk
        for (int v = 0; v < NV; v++) begin
            build_expect(VEC_INSTR[v]);
            check(e_cnt == VEC_CNT[v], "R7", "model count", 64'(e_cnt), 64'(VEC_CNT[v]));
            offer(VEC_INSTR[v]);
            if (VEC_INSTR[v][22]) begin
                #1;
                check(illegal && !out_valid && in_ready, "R1", "illegal flag",
                      {61'd0, illegal, out_valid, in_ready}, 64'b101);
                @(negedge clk);
                #1;
                check(!illegal && !out_valid, "R1", "nothing emitted",
                      {62'd0, illegal, out_valid}, 64'd0);
            end else begin
                collect(VEC_INSTR[v], got);
                check(got == e_cnt, "R7", "stream length", 64'(got), 64'(e_cnt));
                #1;
                check(in_ready && !out_valid, "R7", "idle after last",
                      {62'd0, in_ready, out_valid}, 64'b10);
            end
        end

        // stall hold and ignored instruction while busy
        build_expect(32'hE92D_4FF0);
        offer(32'hE92D_4FF0);
        out_ready = 1'b0;
        #1;
        hold_enc = out_encoding;
        in_instr = 32'hE8BD_0001;
        in_valid = 1'b1;
        @(negedge clk); @(negedge clk); @(negedge clk);
        in_valid = 1'b0;
        #1;
        check(out_valid && out_encoding == hold_enc && out_kind == 2'd0, "R9", "hold under stall",
              64'(out_encoding), 64'(hold_enc));
        collect(32'hE92D_4FF0, got);
        check(got == e_cnt, "R8", "busy offer ignored", 64'(got), 64'(e_cnt));

        // hold during a transfer micro-op
        build_expect(32'hE810_0003);
        offer(32'hE810_0003);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        #1;
        hold_off = out_offset;
        @(negedge clk); @(negedge clk);
        #1;
        check(out_kind == 2'd1 && out_offset == hold_off && out_offset == 7'd4, "R9", "transfer hold",
              64'(out_offset), 64'd4);
        // mid-stream reset
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(in_ready && !out_valid && !illegal, "R10", "reset mid-stream",
              {61'd0, in_ready, out_valid, illegal}, 64'b100);
        @(negedge clk); @(negedge clk);
        #1;
        check(!out_valid, "R10", "stream abandoned", 64'(out_valid), 64'd0);

        // clean run after reset
        build_expect(32'hE9B1_FFFF);
        offer(32'hE9B1_FFFF);
        collect(32'hE9B1_FFFF, got);
        check(got == 18, "R7", "full list after reset", 64'(got), 64'd18);
        finish_up();
    end
endmodule